// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Age-Ordered Dual-Pipe Selection

This block is the wait-and-select stage between register renaming and two execution pipes. Renamed operations enter at up to two per cycle, each carrying two source tags with ready flags, a destination tag, a class that says which pipe may run it, and a fixed result latency. An entry keeps its slot from insertion until issue; nothing moves. An age matrix keeps relative order, so the chosen entry is always the oldest eligible one, wherever it sits in the array.

When the class permits either pipe, a small balancing counter binds the operation to one pipe as it is written. From then on it only competes for that pipe. Result tags broadcast by the pipes wake waiting sources. Each pipe keeps a reservation window for its result bus. An operation whose result cycle is already booked waits, so two results never meet on one bus. Each cycle the block offers at most one operation per pipe, and it raises a stall toward rename when it cannot take two more.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset, no pipe issues, neither result bus is marked busy, and stall is low.
- R2: Each insert port with its valid bit set and stall low creates an entry in the cycle of the clock edge. When both ports insert in one edge, the entry from port 0 counts as older than the one from port 1.
- R3: Stall is high exactly when fewer than two of the 18 entries are free. An insert presented while stall is high is dropped and never issues.
- R4: At most one operation issues per pipe per cycle, and both pipes may issue in the same cycle. Class code 0 runs only on pipe 0, code 1 runs only on pipe 1, and codes 2 and 3 run on either pipe.
- R5: Among the eligible entries bound to a pipe, the oldest by insertion order issues first, whatever its slot position.
- R6: A balancing counter starts at zero. An either-pipe operation goes to pipe 0 and increments the counter when the counter is zero or negative. Otherwise it goes to pipe 1 and decrements the counter. Port 0 is decided before port 1 in the same edge, and fixed-class operations leave the counter unchanged.
- R7: An operation issues only when both of its sources are ready. An operation written with both sources ready can issue in the cycle right after its insert edge.
- R8: A valid wakeup tag that equals a waiting source tag makes that source ready at the next edge, so the operation can issue in the following cycle. A wakeup presented in the same edge as the insert also counts.
- R9: An operation of latency L (1 to 7, code 0 not used) issued in cycle t marks its pipe's result bus busy in cycle t+L. An operation whose result cycle is already booked on its pipe is held back until its slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 2 | Per-port insert request |
| insClass | input | 4 | Per-port class code, 2 bits each (0 pipe 0, 1 pipe 1, 2/3 either) |
| insLat | input | 6 | Per-port result latency, 3 bits each |
| insDst | input | 14 | Per-port destination tag, 7 bits each |
| insSrcTag | input | 28 | Source tags, 7 bits each, port-major then source |
| insSrcRdy | input | 4 | Source ready-at-rename flags, port-major then source |
| wakeValid | input | 2 | Per-broadcast valid |
| wakeTag | input | 14 | Broadcast result tags, 7 bits each |
| stall | output | 1 | Fewer than two free entries |
| issValid | output | 2 | Per-pipe issue strobe |
| issDst | output | 14 | Destination tag of the issued operation per pipe |
| resBusValid | output | 2 | Per-pipe result bus is in use this cycle |

## Verification
The assertions assume that rename never presents an insert with latency code 0 and that it honours stall. They also assume that destination tags of operations in flight are unique, so a broadcast wakes only the intended consumers. The stimulus uses latencies between 1 and 7 and gives every operation its own destination tag. It presents only a deliberate insert while stall is high, to show that the insert is dropped. Wakeup tags are chosen so that each matches only the sources meant to wait on it.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NUM_ENTRIES = 18;
  localparam int TAG_W       = 7;
  localparam int LAT_W       = 3;
  localparam int NUM_PIPES   = 2;
  localparam int INS_W       = 2;
  localparam int WAKE_W      = 2;
  localparam int NUM_SRC     = 2;
  localparam int BAL_W       = 4;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int MAX_LAT     = (1 << LAT_W) - 1;

  typedef enum logic [1:0] {
    CLS_PIPE0  = 2'd0,
    CLS_PIPE1  = 2'd1,
    CLS_EITHER = 2'd2,
    CLS_ANY    = 2'd3
  } opClass_e;

  typedef struct packed {
    logic [INS_W-1:0]                wrEn;
    logic [INS_W-1:0][IDX_W-1:0]     wrIdx;
    logic [INS_W-1:0]                wrPipe;
    logic [NUM_PIPES-1:0]            issEn;
    logic [NUM_PIPES-1:0][IDX_W-1:0] issIdx;
  } iqStrobe_t;
endpackage

// File: rtl/iq_entry_store.sv
module iq_entry_store
  import iq_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rstN,
  input  iqStrobe_t                               strobe,
  input  logic [INS_W*NUM_SRC*TAG_W-1:0]          insSrcTag,
  input  logic [INS_W*NUM_SRC-1:0]                insSrcRdy,
  input  logic [INS_W*LAT_W-1:0]                  insLat,
  input  logic [INS_W*TAG_W-1:0]                  insDst,
  input  logic [WAKE_W-1:0]                       wakeValid,
  input  logic [WAKE_W*TAG_W-1:0]                 wakeTag,
  output logic [NUM_ENTRIES-1:0]                  entValid,
  output logic [NUM_ENTRIES-1:0]                  entRdy,
  output logic [NUM_ENTRIES-1:0]                  entPipe,
  output logic [NUM_ENTRIES-1:0][LAT_W-1:0]       entLat,
  output logic [NUM_ENTRIES-1:0][TAG_W-1:0]       entDst,
  output logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageYounger
);

  logic [NUM_ENTRIES-1:0]                           validQ;
  logic [NUM_ENTRIES-1:0][NUM_SRC-1:0]              srcRdyQ;
  logic [NUM_ENTRIES-1:0][NUM_SRC-1:0][TAG_W-1:0]   srcTagQ;
  logic [NUM_ENTRIES-1:0]                           pipeQ;
  logic [NUM_ENTRIES-1:0][LAT_W-1:0]                latQ;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]                dstQ;
  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0]          youngQ;
  logic [INS_W-1:0][NUM_ENTRIES-1:0]                priorMask;

  function automatic logic wakeHit(input logic [TAG_W-1:0] tag);
    logic hit;
    hit = 1'b0;
    for (int w = 0; w < WAKE_W; w++)
      if (wakeValid[w] && wakeTag[w*TAG_W +: TAG_W] == tag) hit = 1'b1;
    return hit;
  endfunction

  // Entries written earlier in the same edge count as older than later ports.
  always_comb begin
    for (int k = 0; k < INS_W; k++) begin
      priorMask[k] = '0;
      for (int m = 0; m < k; m++)
        if (strobe.wrEn[m]) priorMask[k] = priorMask[k] | (NUM_ENTRIES'(1) << strobe.wrIdx[m]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      srcRdyQ <= '0;
      srcTagQ <= '0;
      pipeQ   <= '0;
      latQ    <= '0;
      dstQ    <= '0;
      youngQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        for (int s = 0; s < NUM_SRC; s++)
          if (validQ[i] && wakeHit(srcTagQ[i][s])) srcRdyQ[i][s] <= 1'b1;
      // Column clears first so that the row writes below take precedence.
      for (int k = 0; k < INS_W; k++)
        if (strobe.wrEn[k])
          for (int j = 0; j < NUM_ENTRIES; j++) youngQ[j][strobe.wrIdx[k]] <= 1'b0;
      for (int k = 0; k < INS_W; k++) begin
        if (strobe.wrEn[k]) begin
          validQ[strobe.wrIdx[k]] <= 1'b1;
          pipeQ[strobe.wrIdx[k]]  <= strobe.wrPipe[k];
          latQ[strobe.wrIdx[k]]   <= insLat[k*LAT_W +: LAT_W];
          dstQ[strobe.wrIdx[k]]   <= insDst[k*TAG_W +: TAG_W];
          youngQ[strobe.wrIdx[k]] <= validQ | priorMask[k];
          for (int s = 0; s < NUM_SRC; s++) begin
            srcTagQ[strobe.wrIdx[k]][s] <= insSrcTag[(k*NUM_SRC+s)*TAG_W +: TAG_W];
            srcRdyQ[strobe.wrIdx[k]][s] <= insSrcRdy[k*NUM_SRC+s] |
                                           wakeHit(insSrcTag[(k*NUM_SRC+s)*TAG_W +: TAG_W]);
          end
        end
      end
      for (int p = 0; p < NUM_PIPES; p++)
        if (strobe.issEn[p]) validQ[strobe.issIdx[p]] <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) entRdy[i] = &srcRdyQ[i];
  end
  assign entValid   = validQ;
  assign entPipe    = pipeQ;
  assign entLat     = latQ;
  assign entDst     = dstQ;
  assign ageYounger = youngQ;

  // Any two live entries must be strictly ordered one way.
  logic ageBad;
  always_comb begin
    ageBad = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      for (int j = 0; j < NUM_ENTRIES; j++)
        if (i != j && validQ[i] && validQ[j] && youngQ[i][j] == youngQ[j][i]) ageBad = 1'b1;
  end

  p_age_total_r5: assert property (@(posedge clk) disable iff (!rstN) !ageBad);

  for (genvar k = 0; k < INS_W; k++) begin : g_wrChk
    p_write_free_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrEn[k] |-> !validQ[strobe.wrIdx[k]]);
    p_lat_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrEn[k] |-> insLat[k*LAT_W +: LAT_W] != '0);
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_issChk
    p_issue_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.issEn[p] |-> (validQ[strobe.issIdx[p]] && pipeQ[strobe.issIdx[p]] == 1'(p)));
    p_issue_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
      strobe.issEn[p] |-> &srcRdyQ[strobe.issIdx[p]]);
  end

endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick
  import iq_pkg::*;
#(
  parameter  int N  = NUM_ENTRIES,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        cand,
  input  logic [N-1:0][N-1:0] younger,
  output logic                grantAny,
  output logic [IW-1:0]       grantIdx
);

  logic [N-1:0] win;

  // A candidate wins when no other candidate is older than it.
  for (genvar i = 0; i < N; i++) begin : g_win
    assign win[i] = cand[i] && !(|(younger[i] & cand));
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) grantIdx = IW'(i);
  end
  assign grantAny = |win;

  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rstN) $onehot0(win));
  p_winner_exists_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cand != '0) |-> (win != '0));

endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [INS_W-1:0]                        insValid,
  input  logic [INS_W*2-1:0]                      insClass,
  input  logic [NUM_ENTRIES-1:0]                  entValid,
  input  logic [NUM_ENTRIES-1:0]                  entRdy,
  input  logic [NUM_ENTRIES-1:0]                  entPipe,
  input  logic [NUM_ENTRIES-1:0][LAT_W-1:0]       entLat,
  input  logic [NUM_ENTRIES-1:0][TAG_W-1:0]       entDst,
  input  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageYounger,
  output iqStrobe_t                               strobe,
  output logic                                    stall,
  output logic [NUM_PIPES-1:0]                    issValid,
  output logic [NUM_PIPES*TAG_W-1:0]              issDst,
  output logic [NUM_PIPES-1:0]                    resBusValid
);

  logic [IDX_W-1:0]                    freeA, freeB;
  logic [$clog2(NUM_ENTRIES+1)-1:0]    freeCnt;
  logic [BAL_W-1:0]                    balQ, balN;
  logic [NUM_PIPES-1:0][MAX_LAT:0]     busyQ, busyN;
  logic [NUM_PIPES-1:0][NUM_ENTRIES-1:0] cand;
  logic [NUM_PIPES-1:0]                pickAny;
  logic [NUM_PIPES-1:0][IDX_W-1:0]     pickIdx;
  logic [NUM_PIPES-1:0][LAT_W-1:0]     pickLat;

  // Lowest two free slots.
  always_comb begin
    logic gotA, gotB;
    freeA = '0;
    freeB = '0;
    gotA  = 1'b0;
    gotB  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!entValid[i]) begin
        if (!gotA) begin
          freeA = IDX_W'(i);
          gotA  = 1'b1;
        end else if (!gotB) begin
          freeB = IDX_W'(i);
          gotB  = 1'b1;
        end
      end
    end
    freeCnt = $bits(freeCnt)'($countones(~entValid));
  end

  assign stall = freeCnt < 2;

  // Slot assignment and pipe binding, port 0 first.
  always_comb begin
    int used;
    logic [BAL_W-1:0] bal;
    used = 0;
    bal  = balQ;
    strobe.wrEn   = '0;
    strobe.wrIdx  = '0;
    strobe.wrPipe = '0;
    for (int k = 0; k < INS_W; k++) begin
      if (insValid[k] && !stall) begin
        strobe.wrEn[k]  = 1'b1;
        strobe.wrIdx[k] = (used == 0) ? freeA : freeB;
        used = used + 1;
        if (insClass[k*2+1]) begin
          if (!bal[BAL_W-1] && bal != '0) begin
            strobe.wrPipe[k] = 1'b1;
            bal = bal - 1'b1;
          end else begin
            strobe.wrPipe[k] = 1'b0;
            bal = bal + 1'b1;
          end
        end else begin
          strobe.wrPipe[k] = insClass[k*2];
        end
      end
    end
    balN = bal;
  end

  // Per-pipe selection with result-slot filtering.
  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cand
      assign cand[p][i] = entValid[i] && entRdy[i] && (entPipe[i] == 1'(p)) &&
                          !busyQ[p][entLat[i]];
    end

    iq_age_pick #(.N(NUM_ENTRIES)) u_pick (
      .clk      (clk),
      .rstN     (rstN),
      .cand     (cand[p]),
      .younger  (ageYounger),
      .grantAny (pickAny[p]),
      .grantIdx (pickIdx[p])
    );

    assign pickLat[p]                = entLat[pickIdx[p]];
    assign issValid[p]               = pickAny[p];
    assign issDst[p*TAG_W +: TAG_W]  = entDst[pickIdx[p]];
    assign resBusValid[p]            = busyQ[p][0];
    assign strobe.issEn[p]           = pickAny[p];
    assign strobe.issIdx[p]          = pickIdx[p];

    // Window bit j means the bus is booked j cycles from now.
    always_comb begin
      for (int j = 0; j < MAX_LAT; j++)
        busyN[p][j] = busyQ[p][j+1] | (pickAny[p] && pickLat[p] == LAT_W'(j+1));
      busyN[p][MAX_LAT] = 1'b0;
    end

    p_no_double_book_r9: assert property (@(posedge clk) disable iff (!rstN)
      pickAny[p] |-> !busyQ[p][pickLat[p]]);
    p_slot_booked_r9: assert property (@(posedge clk) disable iff (!rstN)
      (pickAny[p] && pickLat[p] > LAT_W'(1)) |=> busyQ[p][$past(pickLat[p]) - 1'b1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      balQ  <= '0;
      busyQ <= '0;
    end else begin
      balQ  <= balN;
      busyQ <= busyN;
    end
  end

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (strobe.wrEn == '0));
  p_balance_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    (balQ == BAL_W'(0)) || (balQ == BAL_W'(1)));
  p_dual_distinct_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pickAny == '1) |-> (pickIdx[0] != pickIdx[1]));

endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue
  import iq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [INS_W-1:0]               insValid,
  input  logic [INS_W*2-1:0]             insClass,
  input  logic [INS_W*LAT_W-1:0]         insLat,
  input  logic [INS_W*TAG_W-1:0]         insDst,
  input  logic [INS_W*NUM_SRC*TAG_W-1:0] insSrcTag,
  input  logic [INS_W*NUM_SRC-1:0]       insSrcRdy,
  input  logic [WAKE_W-1:0]              wakeValid,
  input  logic [WAKE_W*TAG_W-1:0]        wakeTag,
  output logic                           stall,
  output logic [NUM_PIPES-1:0]           issValid,
  output logic [NUM_PIPES*TAG_W-1:0]     issDst,
  output logic [NUM_PIPES-1:0]           resBusValid
);

  iqStrobe_t                               strobe;
  logic [NUM_ENTRIES-1:0]                  entValid, entRdy, entPipe;
  logic [NUM_ENTRIES-1:0][LAT_W-1:0]       entLat;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]       entDst;
  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] ageYounger;

  iq_entry_store u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .insSrcTag  (insSrcTag),
    .insSrcRdy  (insSrcRdy),
    .insLat     (insLat),
    .insDst     (insDst),
    .wakeValid  (wakeValid),
    .wakeTag    (wakeTag),
    .entValid   (entValid),
    .entRdy     (entRdy),
    .entPipe    (entPipe),
    .entLat     (entLat),
    .entDst     (entDst),
    .ageYounger (ageYounger)
  );

  iq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .insValid    (insValid),
    .insClass    (insClass),
    .entValid    (entValid),
    .entRdy      (entRdy),
    .entPipe     (entPipe),
    .entLat      (entLat),
    .entDst      (entDst),
    .ageYounger  (ageYounger),
    .strobe      (strobe),
    .stall       (stall),
    .issValid    (issValid),
    .issDst      (issDst),
    .resBusValid (resBusValid)
  );

endmodule

// File: tb/sim_ooo_issue_queue.sv
module sim_ooo_issue_queue;
  import iq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [INS_W-1:0]               insValid = '0;
  logic [INS_W*2-1:0]             insClass = '0;
  logic [INS_W*LAT_W-1:0]         insLat = '0;
  logic [INS_W*TAG_W-1:0]         insDst = '0;
  logic [INS_W*NUM_SRC*TAG_W-1:0] insSrcTag = '0;
  logic [INS_W*NUM_SRC-1:0]       insSrcRdy = '0;
  logic [WAKE_W-1:0]              wakeValid = '0;
  logic [WAKE_W*TAG_W-1:0]        wakeTag = '0;
  logic                           stall;
  logic [NUM_PIPES-1:0]           issValid;
  logic [NUM_PIPES*TAG_W-1:0]     issDst;
  logic [NUM_PIPES-1:0]           resBusValid;

  ooo_issue_queue u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    int    dst;
    int    lat;
    string req;
  } expItem_t;

  expItem_t q0[$];
  expItem_t q1[$];
  bit  expBus[2][16];
  int  issCyc[128];
  int  cyc = 0;
  int  errors = 0;
  int  checks = 0;
  bit  running = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    insValid  = '0;
    wakeValid = '0;
  endtask

  task automatic setOp(input int k, input int cls, input int lat, input int dst,
                       input int t0, input bit r0, input int t1, input bit r1);
    insValid[k]                             = 1'b1;
    insClass[k*2 +: 2]                      = 2'(cls);
    insLat[k*LAT_W +: LAT_W]                = LAT_W'(lat);
    insDst[k*TAG_W +: TAG_W]                = TAG_W'(dst);
    insSrcTag[(k*NUM_SRC)*TAG_W +: TAG_W]   = TAG_W'(t0);
    insSrcTag[(k*NUM_SRC+1)*TAG_W +: TAG_W] = TAG_W'(t1);
    insSrcRdy[k*NUM_SRC]                    = r0;
    insSrcRdy[k*NUM_SRC+1]                  = r1;
  endtask

  task automatic expectIss(input int p, input int dst, input int lat, input string req);
    expItem_t it;
    it.dst = dst;
    it.lat = lat;
    it.req = req;
    if (p == 0) q0.push_back(it);
    else q1.push_back(it);
  endtask

  task automatic setWake(input int w, input int tag);
    wakeValid[w]                 = 1'b1;
    wakeTag[w*TAG_W +: TAG_W]    = TAG_W'(tag);
  endtask

  task automatic drain();
    int waited;
    waited = 0;
    while ((q0.size() != 0 || q1.size() != 0) && waited < 200) begin
      tick();
      waited++;
    end
    tick();
    tick();
    tick();
  endtask

  // Monitor: result-bus scoreboard and per-pipe issue order.
  always @(negedge clk) begin
    if (running) begin
      for (int p = 0; p < 2; p++) begin
        chk(resBusValid[p] == expBus[p][cyc % 16], "R9", $sformatf("result bus pipe%0d cycle %0d", p, cyc),
            int'(resBusValid[p]), int'(expBus[p][cyc % 16]));
        expBus[p][cyc % 16] = 1'b0;
        if (issValid[p]) begin
          int got;
          expItem_t it;
          got = int'(issDst[p*TAG_W +: TAG_W]);
          issCyc[got] = cyc;
          if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
            chk(1'b0, "R4", $sformatf("unexpected issue on pipe%0d", p), got, -1);
          end else begin
            it = (p == 0) ? q0.pop_front() : q1.pop_front();
            chk(got == it.dst, it.req, $sformatf("issue order pipe%0d", p), got, it.dst);
            expBus[p][(cyc + it.lat) % 16] = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k0;
    int kw;
    for (int i = 0; i < 128; i++) issCyc[i] = -1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);
    chk(issValid == '0, "R1", "issue after reset", int'(issValid), 0);
    chk(resBusValid == '0, "R1", "bus after reset", int'(resBusValid), 0);
    running = 1'b1;

    // R5/R7/R8: oldest first when the older entry sits in a higher slot
    tick();
    setOp(0, 0, 1, 1, 100, 1, 101, 1);
    expectIss(0, 1, 1, "R7");
    setOp(1, 0, 1, 2, 21, 0, 5, 1);
    expectIss(0, 2, 1, "R5");
    k0 = cyc;
    tick();
    tick();
    setOp(0, 0, 1, 3, 22, 0, 6, 1);
    expectIss(0, 3, 1, "R5");
    tick();
    setWake(0, 21);
    setWake(1, 22);
    kw = cyc;
    drain();
    chk(issCyc[1] == k0 + 1, "R7", "ready-at-insert issue cycle", issCyc[1], k0 + 1);
    chk(issCyc[2] == kw + 1, "R8", "woken older op issue cycle", issCyc[2], kw + 1);
    chk(issCyc[3] == kw + 2, "R5", "younger op after older", issCyc[3], kw + 2);

    // R8: wakeup in the same edge as the insert
    tick();
    setOp(0, 1, 1, 4, 30, 0, 31, 1);
    setWake(0, 30);
    expectIss(1, 4, 1, "R8");
    k0 = cyc;
    drain();
    chk(issCyc[4] == k0 + 1, "R8", "same-edge wakeup issue cycle", issCyc[4], k0 + 1);

    // R6: balancing of either-pipe ops; R2 port order; R4 dual issue
    tick();
    setOp(0, 2, 1, 10, 1, 1, 2, 1);
    expectIss(0, 10, 1, "R6");
    setOp(1, 2, 1, 11, 1, 1, 2, 1);
    expectIss(1, 11, 1, "R6");
    tick();
    setOp(0, 3, 1, 12, 1, 1, 2, 1);
    expectIss(0, 12, 1, "R6");
    setOp(1, 2, 1, 13, 1, 1, 2, 1);
    expectIss(1, 13, 1, "R6");
    tick();
    setOp(0, 2, 1, 14, 1, 1, 2, 1);
    expectIss(0, 14, 1, "R6");
    tick();
    setOp(1, 2, 1, 15, 1, 1, 2, 1);
    expectIss(1, 15, 1, "R6");
    tick();
    setOp(0, 1, 1, 16, 1, 1, 2, 1);
    expectIss(1, 16, 1, "R4");
    setOp(1, 2, 1, 17, 1, 1, 2, 1);
    expectIss(0, 17, 1, "R6");
    drain();
    chk(issCyc[10] == issCyc[11], "R4", "both pipes issue together", issCyc[11], issCyc[10]);

    // R9: result-slot conflict holds back a short op
    tick();
    setOp(0, 1, 3, 20, 1, 1, 2, 1);
    expectIss(1, 20, 3, "R9");
    setOp(1, 0, 7, 22, 1, 1, 2, 1);
    expectIss(0, 22, 7, "R9");
    tick();
    tick();
    setOp(0, 1, 1, 21, 1, 1, 2, 1);
    expectIss(1, 21, 1, "R9");
    drain();
    chk(issCyc[21] == issCyc[20] + 3, "R9", "held op issue cycle", issCyc[21], issCyc[20] + 3);

    // R3: fill to stall, dropped insert, then release
    for (int c = 0; c < 8; c++) begin
      tick();
      setOp(0, 0, 1, 30 + 2*c, 50, 0, 1, 1);
      expectIss(0, 30 + 2*c, 1, "R2");
      setOp(1, 0, 1, 31 + 2*c, 50, 0, 1, 1);
      expectIss(0, 31 + 2*c, 1, "R2");
    end
    tick();
    chk(stall == 1'b0, "R3", "stall with two free", int'(stall), 0);
    setOp(0, 0, 1, 46, 50, 0, 1, 1);
    expectIss(0, 46, 1, "R3");
    tick();
    chk(stall == 1'b1, "R3", "stall with one free", int'(stall), 1);
    setOp(0, 0, 1, 60, 1, 1, 2, 1);
    tick();
    chk(stall == 1'b1, "R3", "stall holds after dropped insert", int'(stall), 1);
    chk(issValid == '0, "R3", "dropped insert does not issue", int'(issValid), 0);
    setWake(0, 50);
    drain();
    chk(issCyc[60] == -1, "R3", "dropped op never issued", issCyc[60], -1);
    chk(stall == 1'b0, "R3", "stall clears after drain", int'(stall), 0);

    chk(q0.size() == 0 && q1.size() == 0, "R4", "pending expected issues", q0.size() + q1.size(), 0);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule